// File: doc/BRIEF.md
# Circular buffer write window limiter

A producer writes into a circular buffer it shares with a consumer. Before each write run the producer must know how far it may go without overwriting data the consumer has not read yet. This block computes that bound. It takes three monotonically increasing byte indices: head, the free size, and a wakeup point. It also takes the buffer size as a log2 page count and a snapshot flag. From these it returns a page-aligned limit offset, where zero means the producer must stay disabled. It also returns the number of bytes to fill with the ignore byte, the head index after that fill, and a truncation flag.

Every index is reduced to an offset inside the buffer by masking. A misaligned head is first padded up to the write alignment. The limit is then taken from the tail, rounded down to a page, or from the buffer end, and is lowered to the page after the wakeup point when that point falls inside the window. A window that is empty is padded away and reported as truncated. A window that is too short for a useful run is padded and computed a second time. In snapshot mode the whole buffer is always handed out.

A single-cycle start pulse launches the computation. A single-cycle done pulse marks the outputs valid. Page size, write alignment and minimum run length are parameters.

Top module: `wl_window_limiter`

## Requirements
- R1: While reset is asserted and after its release, done_o, limit_o, pad_len_o, head_o, trunc_o and cfg_err_o are all zero.
- R2: A page count code pages_log2_i of 0 (fewer than two pages) or above MAX_PAGES_LOG2 gives done_o with cfg_err_o=1, limit_o=0, pad_len_o=0, trunc_o=0 and head_o equal to the head sampled at start.
- R3: With snapshot_i=1 and a valid page count, limit_o is the full buffer size of 2^(PAGE_LOG2+pages_log2_i) bytes, pad_len_o is 0, head_o is the start head and trunc_o is 0.
- R4: A head offset that is not a multiple of 2^ALIGN_LOG2 is padded up to the next such multiple. The pad is capped at size, and head and size advance by the pad. head_o always equals the start head plus pad_len_o.
- R5: If the size is zero after alignment, trunc_o=1 and limit_o=0.
- R6: With tail = (head+size) mod buffer size, the limit is the tail rounded down to a page when head offset < tail, and otherwise the buffer size. Every limit_o is a multiple of the page size.
- R7: When wakeup < head+size (full indices) and the wakeup offset is at or above the head offset, the limit becomes the smaller of the R6 limit and the wakeup offset rounded up to a page.
- R8: If the computed limit is not above the head offset, the whole remaining size is padded, trunc_o=1 and limit_o=0. Otherwise limit_o is above the head offset of head_o.
- R9: On the first pass only, if the limit is fewer than MIN_RUN bytes beyond the head offset, the gap is padded and the limit is computed once more. That second result is final.
- R10: pad_byte_o, the ignore fill value, is always 0x70.
- R11: done_o is a one-cycle pulse. It rises two cycles after the start edge per pass, or one cycle after for snapshot and configuration errors. start_i is ignored while a computation is in progress.
- The size input must not exceed the buffer size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start_i | input | 1 | Begin a computation (sampled when idle) |
| head_i | input | IDX_W | Producer head index |
| size_i | input | IDX_W | Free space in bytes |
| wakeup_i | input | IDX_W | Wakeup index |
| snapshot_i | input | 1 | Snapshot mode: hand out the whole buffer |
| pages_log2_i | input | PL_W | log2 of the page count |
| done_o | output | 1 | One-cycle pulse, outputs valid |
| limit_o | output | OFF_W | Limit offset, zero means stay disabled |
| pad_len_o | output | IDX_W | Bytes to fill with the ignore byte |
| head_o | output | IDX_W | Head index after padding |
| trunc_o | output | 1 | Window was truncated |
| cfg_err_o | output | 1 | Page count out of range |
| pad_byte_o | output | 8 | Ignore fill byte value |

## Verification
The hardest case to reach is the second pass. It needs a head that lands, after alignment, inside the last page before a tail or wakeup bound. It also needs enough free size that the first limit is valid but under MIN_RUN bytes away. The stimulus sweeps head across two buffer lengths in steps that are coprime to the page and alignment sizes. For each head it places the wakeup just behind the head, inside the window, or just past its end, over a range of sizes. This makes short gaps, wrapped tails, in-window wakeups and full-size windows all occur. Every result is compared against an arithmetic model using division and modulo.

// File: rtl/wl_pkg.sv
package wl_pkg;
  localparam logic [7:0] WL_PAD_BYTE = 8'h70;

  typedef enum logic [1:0] {
    WL_IDLE  = 2'd0,
    WL_ALIGN = 2'd1,
    WL_LIMIT = 2'd2
  } wl_state_e;
endpackage

// File: rtl/wl_reduce.sv
module wl_reduce #(
  parameter int IDX_W = 16,
  parameter int OFF_W = 10
) (
  input  logic [IDX_W-1:0] idx_i,
  input  logic [IDX_W-1:0] mask_i,
  output logic [OFF_W-1:0] off_o
);
  logic [IDX_W-1:0] masked;

  always_comb begin
    masked = idx_i & mask_i;
    off_o  = OFF_W'(masked);
  end
endmodule

// File: rtl/wl_align.sv
module wl_align #(
  parameter int IDX_W      = 16,
  parameter int OFF_W      = 10,
  parameter int ALIGN_LOG2 = 3
) (
  input  logic [OFF_W-1:0] head_off_i,
  input  logic [IDX_W-1:0] size_i,
  output logic [IDX_W-1:0] pad_o
);
  localparam logic [OFF_W-1:0] AL_MASK = OFF_W'((1 << ALIGN_LOG2) - 1);

  logic [OFF_W-1:0] rounded;
  logic [OFF_W-1:0] gap;
  logic [IDX_W-1:0] gap_ext;

  always_comb begin
    rounded = (head_off_i + AL_MASK) & ~AL_MASK;
    gap     = rounded - head_off_i;
    gap_ext = IDX_W'(gap);
    pad_o   = (gap_ext < size_i) ? gap_ext : size_i;
  end
endmodule

// File: rtl/wl_limit.sv
module wl_limit #(
  parameter int OFF_W     = 10,
  parameter int PAGE_LOG2 = 6
) (
  input  logic [OFF_W-1:0] head_off_i,
  input  logic [OFF_W-1:0] tail_off_i,
  input  logic [OFF_W-1:0] wake_off_i,
  input  logic [OFF_W-1:0] buf_size_i,
  input  logic             wake_hit_i,
  output logic [OFF_W-1:0] limit_o
);
  localparam logic [OFF_W-1:0] PG_MASK = OFF_W'((1 << PAGE_LOG2) - 1);

  logic [OFF_W-1:0] base_lim;
  logic [OFF_W-1:0] wake_up;
  logic             wake_low;

  always_comb begin
    base_lim = (head_off_i < tail_off_i) ? (tail_off_i & ~PG_MASK) : buf_size_i;
    wake_up  = (wake_off_i + PG_MASK) & ~PG_MASK;
    wake_low = wake_hit_i && (head_off_i <= wake_off_i) && (wake_up < base_lim);
    limit_o  = wake_low ? wake_up : base_lim;
  end
endmodule

// File: rtl/wl_window_limiter.sv
module wl_window_limiter #(
  parameter int IDX_W          = 16,
  parameter int PAGE_LOG2      = 6,
  parameter int MAX_PAGES_LOG2 = 3,
  parameter int PL_W           = 3,
  parameter int ALIGN_LOG2     = 3,
  parameter int MIN_RUN        = 64,
  localparam int OFF_W         = PAGE_LOG2 + MAX_PAGES_LOG2 + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [IDX_W-1:0] head_i,
  input  logic [IDX_W-1:0] size_i,
  input  logic [IDX_W-1:0] wakeup_i,
  input  logic             snapshot_i,
  input  logic [PL_W-1:0]  pages_log2_i,
  output logic             done_o,
  output logic [OFF_W-1:0] limit_o,
  output logic [IDX_W-1:0] pad_len_o,
  output logic [IDX_W-1:0] head_o,
  output logic             trunc_o,
  output logic             cfg_err_o,
  output logic [7:0]       pad_byte_o
);
  import wl_pkg::*;

  localparam int               N_RED    = 3;
  localparam logic [PL_W-1:0]  MAXPL_V  = PL_W'(MAX_PAGES_LOG2);
  localparam logic [OFF_W-1:0] MIN_V    = OFF_W'(MIN_RUN);
  localparam logic [OFF_W-1:0] OFF_ONE  = OFF_W'(1);
  localparam logic [IDX_W-1:0] IDX_ONE  = IDX_W'(1);

  // reset synchronizer: asserts at once, releases on the clock
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // state
  wl_state_e        state_q, state_d;
  logic             pass_q, pass_d;
  logic [IDX_W-1:0] head_q, head_d;
  logic [IDX_W-1:0] size_q, size_d;
  logic [IDX_W-1:0] wake_q, wake_d;
  logic [IDX_W-1:0] pad_q, pad_d;
  logic [IDX_W-1:0] base_head_q, base_head_d;
  logic [PL_W-1:0]  pl_q, pl_d;
  logic             snap_q, snap_d;
  logic [OFF_W-1:0] lim_q, lim_d;
  logic             trunc_q, trunc_d;
  logic             cfg_q, cfg_d;
  logic             done_q, done_d;
  logic             dp_en;

  // datapath
  int unsigned      shamt;
  logic [IDX_W-1:0] idx_mask;
  logic [OFF_W-1:0] buf_size;
  logic             cfg_bad;
  logic [IDX_W-1:0] head_plus_size;
  logic             wake_hit;
  logic [IDX_W-1:0] red_in  [N_RED];
  logic [OFF_W-1:0] red_out [N_RED];
  logic [OFF_W-1:0] head_off, tail_off, wake_off;
  logic [IDX_W-1:0] align_pad;
  logic [OFF_W-1:0] limit_c;
  logic [OFF_W-1:0] gap;
  logic [IDX_W-1:0] gap_ext;

  always_comb begin
    shamt          = PAGE_LOG2 + 32'(pl_q);
    idx_mask       = (IDX_ONE << shamt) - IDX_ONE;
    buf_size       = OFF_ONE << shamt;
    cfg_bad        = (pl_q == '0) || (pl_q > MAXPL_V);
    head_plus_size = head_q + size_q;
    wake_hit       = wake_q < head_plus_size;
    red_in[0]      = head_q;
    red_in[1]      = head_plus_size;
    red_in[2]      = wake_q;
  end

  genvar g;
  generate
    for (g = 0; g < N_RED; g++) begin : g_red
      wl_reduce #(.IDX_W(IDX_W), .OFF_W(OFF_W)) u_red (
        .idx_i  (red_in[g]),
        .mask_i (idx_mask),
        .off_o  (red_out[g])
      );
    end
  endgenerate

  assign head_off = red_out[0];
  assign tail_off = red_out[1];
  assign wake_off = red_out[2];

  wl_align #(.IDX_W(IDX_W), .OFF_W(OFF_W), .ALIGN_LOG2(ALIGN_LOG2)) u_align (
    .head_off_i (head_off),
    .size_i     (size_q),
    .pad_o      (align_pad)
  );

  wl_limit #(.OFF_W(OFF_W), .PAGE_LOG2(PAGE_LOG2)) u_limit (
    .head_off_i (head_off),
    .tail_off_i (tail_off),
    .wake_off_i (wake_off),
    .buf_size_i (buf_size),
    .wake_hit_i (wake_hit),
    .limit_o    (limit_c)
  );

  always_comb begin
    gap     = limit_c - head_off;
    gap_ext = IDX_W'(gap);
  end

  // next state
  always_comb begin
    state_d     = state_q;
    pass_d      = pass_q;
    head_d      = head_q;
    size_d      = size_q;
    wake_d      = wake_q;
    pad_d       = pad_q;
    base_head_d = base_head_q;
    pl_d        = pl_q;
    snap_d      = snap_q;
    lim_d       = lim_q;
    trunc_d     = trunc_q;
    cfg_d       = cfg_q;
    done_d      = 1'b0;
    unique case (state_q)
      WL_IDLE: begin
        if (start_i) begin
          head_d      = head_i;
          base_head_d = head_i;
          size_d      = size_i;
          wake_d      = wakeup_i;
          pl_d        = pages_log2_i;
          snap_d      = snapshot_i;
          pad_d       = '0;
          pass_d      = 1'b0;
          lim_d       = '0;
          trunc_d     = 1'b0;
          cfg_d       = 1'b0;
          state_d     = WL_ALIGN;
        end
      end
      WL_ALIGN: begin
        if (cfg_bad) begin
          cfg_d   = 1'b1;
          lim_d   = '0;
          done_d  = 1'b1;
          state_d = WL_IDLE;
        end else if (snap_q) begin
          lim_d   = buf_size;
          done_d  = 1'b1;
          state_d = WL_IDLE;
        end else begin
          head_d  = head_q + align_pad;
          size_d  = size_q - align_pad;
          pad_d   = pad_q + align_pad;
          state_d = WL_LIMIT;
        end
      end
      WL_LIMIT: begin
        if (size_q == '0) begin
          trunc_d = 1'b1;
          lim_d   = '0;
          done_d  = 1'b1;
          state_d = WL_IDLE;
        end else if (limit_c <= head_off) begin
          pad_d   = pad_q + size_q;
          head_d  = head_q + size_q;
          size_d  = '0;
          trunc_d = 1'b1;
          lim_d   = '0;
          done_d  = 1'b1;
          state_d = WL_IDLE;
        end else if (!pass_q && (gap < MIN_V)) begin
          pad_d   = pad_q + gap_ext;
          head_d  = head_q + gap_ext;
          size_d  = size_q - gap_ext;
          pass_d  = 1'b1;
          state_d = WL_ALIGN;
        end else begin
          lim_d   = limit_c;
          done_d  = 1'b1;
          state_d = WL_IDLE;
        end
      end
      default: state_d = WL_IDLE;
    endcase
  end

  assign dp_en = (state_q != WL_IDLE) || start_i;

  // registers
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state_q <= WL_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      pass_q      <= 1'b0;
      head_q      <= '0;
      size_q      <= '0;
      wake_q      <= '0;
      pad_q       <= '0;
      base_head_q <= '0;
      pl_q        <= '0;
      snap_q      <= 1'b0;
      lim_q       <= '0;
      trunc_q     <= 1'b0;
      cfg_q       <= 1'b0;
    end else if (dp_en) begin
      pass_q      <= pass_d;
      head_q      <= head_d;
      size_q      <= size_d;
      wake_q      <= wake_d;
      pad_q       <= pad_d;
      base_head_q <= base_head_d;
      pl_q        <= pl_d;
      snap_q      <= snap_d;
      lim_q       <= lim_d;
      trunc_q     <= trunc_d;
      cfg_q       <= cfg_d;
    end
  end

  assign done_o     = done_q;
  assign limit_o    = lim_q;
  assign pad_len_o  = pad_q;
  assign head_o     = head_q;
  assign trunc_o    = trunc_q;
  assign cfg_err_o  = cfg_q;
  assign pad_byte_o = WL_PAD_BYTE;

  // checks
  AST_PAD_CAP: assert property (@(posedge clk) disable iff (!rst_int_n)
    (state_q == WL_ALIGN) |-> (align_pad <= size_q)); // R4
  AST_HEAD_ADVANCE: assert property (@(posedge clk) disable iff (!rst_int_n)
    done_o |-> (head_o == base_head_q + pad_len_o)); // R4
  AST_LIMIT_PAGED: assert property (@(posedge clk) disable iff (!rst_int_n)
    done_o |-> (limit_o[PAGE_LOG2-1:0] == '0)); // R6
  AST_TRUNC_NO_LIMIT: assert property (@(posedge clk) disable iff (!rst_int_n)
    (done_o && trunc_o) |-> (limit_o == '0)); // R5
  AST_LIMIT_PAST_HEAD: assert property (@(posedge clk) disable iff (!rst_int_n)
    (done_o && (limit_o != '0)) |-> (limit_o > head_off)); // R8
  AST_CFG_QUIET: assert property (@(posedge clk) disable iff (!rst_int_n)
    (done_o && cfg_err_o) |-> ((limit_o == '0) && (pad_len_o == '0) && !trunc_o)); // R2
  AST_SNAP_FULL: assert property (@(posedge clk) disable iff (!rst_int_n)
    (done_o && snap_q && !cfg_err_o) |-> ((limit_o == buf_size) && (pad_len_o == '0))); // R3
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_int_n)
    done_o |=> !done_o); // R11
endmodule

// File: tb/wl_window_limiter_test.sv
module wl_window_limiter_test;
  localparam int IDX_W = 16;
  localparam int OFF_W = 10;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             start_i;
  logic [IDX_W-1:0] head_i, size_i, wakeup_i;
  logic             snapshot_i;
  logic [2:0]       pages_log2_i;
  logic             done_o;
  logic [OFF_W-1:0] limit_o;
  logic [IDX_W-1:0] pad_len_o, head_o;
  logic             trunc_o, cfg_err_o;
  logic [7:0]       pad_byte_o;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #4 clk = ~clk;

  wl_window_limiter uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .head_i(head_i),
    .size_i(size_i), .wakeup_i(wakeup_i), .snapshot_i(snapshot_i),
    .pages_log2_i(pages_log2_i), .done_o(done_o), .limit_o(limit_o),
    .pad_len_o(pad_len_o), .head_o(head_o), .trunc_o(trunc_o),
    .cfg_err_o(cfg_err_o), .pad_byte_o(pad_byte_o)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 190000) begin
      checks = checks + 1;
      fails  = fails + 1;
      $display("FAIL watchdog: run did not finish (actual %0d cycles, expected < 190000)", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input string msg);
    checks = checks + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s %s", tag, msg);
    end
  endtask

  task automatic model(input int h0, input int s0, input int w, input int pl,
                       input bit snap, output int lim, output int pad,
                       output int hout, output bit tr, output bit cfg,
                       output int lat, output string tag);
    int h, s, bs, ho, t, wo, d, r, gap;
    h = h0; s = s0; pad = 0; tr = 0; cfg = 0; lim = 0; tag = "R6";
    if (pl == 0 || pl > 3) begin
      cfg = 1; hout = h; lat = 1; tag = "R2";
      return;
    end
    bs = 64 << pl;
    if (snap) begin
      lim = bs; hout = h; lat = 1; tag = "R3";
      return;
    end
    lat = 0;
    for (int p = 0; p < 2; p++) begin
      lat = lat + 2;
      ho = h % bs;
      if (ho % 8 != 0) begin
        d = (ho / 8 + 1) * 8 - ho;
        if (d > s) d = s;
        pad = pad + d; h = h + d; s = s - d; ho = h % bs;
        tag = "R4";
      end
      if (s == 0) begin
        tr = 1; lim = 0; tag = "R5";
        break;
      end
      t = (h + s) % bs;
      wo = w % bs;
      lim = bs;
      if (ho < t) lim = (t / 64) * 64;
      if (w < h + s && ho <= wo) begin
        r = ((wo + 63) / 64) * 64;
        if (r < lim) begin
          lim = r; tag = "R7";
        end
      end
      if (lim <= ho) begin
        pad = pad + s; h = h + s; s = 0; tr = 1; lim = 0; tag = "R8";
        break;
      end
      if (p == 0 && lim - ho < 64) begin
        gap = lim - ho;
        pad = pad + gap; h = h + gap; s = s - gap; tag = "R9";
        continue;
      end
      break;
    end
    hout = h;
  endtask

  task automatic launch(input int h, input int s, input int w, input int pl, input bit snap);
    head_i = h[IDX_W-1:0]; size_i = s[IDX_W-1:0]; wakeup_i = w[IDX_W-1:0];
    pages_log2_i = pl[2:0]; snapshot_i = snap;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic wait_done(output int lat);
    lat = 0;
    while (!done_o && lat < 20) begin
      @(negedge clk);
      lat = lat + 1;
    end
  endtask

  task automatic run_case(input int h, input int s, input int w, input int pl, input bit snap);
    int elim, epad, ehead, elat, lat;
    bit etr, ecfg, ok;
    string tag;
    model(h, s, w, pl, snap, elim, epad, ehead, etr, ecfg, elat, tag);
    launch(h, s, w, pl, snap);
    wait_done(lat);
    ok = (int'(limit_o) == elim) && (int'(pad_len_o) == epad) &&
         (int'(head_o) == ehead) && (trunc_o == etr) && (cfg_err_o == ecfg) &&
         (lat == elat) && done_o;
    check(ok, tag, $sformatf(
      "h=%0d s=%0d w=%0d pl=%0d snap=%0b: limit %0d exp %0d, pad %0d exp %0d, head %0d exp %0d, trunc %0b exp %0b, cfg %0b exp %0b, lat %0d exp %0d",
      h, s, w, pl, snap, limit_o, elim, pad_len_o, epad, head_o, ehead,
      trunc_o, etr, cfg_err_o, ecfg, lat, elat));
    @(negedge clk);
  endtask

  initial begin
    int lat, extra;
    rst_n = 1'b0; start_i = 1'b0; head_i = '0; size_i = '0; wakeup_i = '0;
    snapshot_i = 1'b0; pages_log2_i = 3'd1;
    repeat (3) @(negedge clk);
    // R1: outputs idle in reset
    check(!done_o && limit_o == '0 && pad_len_o == '0 && head_o == '0 && !trunc_o && !cfg_err_o,
          "R1", $sformatf("reset outputs: done %0b limit %0d pad %0d head %0d trunc %0b cfg %0b, exp all 0",
          done_o, limit_o, pad_len_o, head_o, trunc_o, cfg_err_o));
    // R10: fill value
    check(pad_byte_o == 8'h70, "R10", $sformatf("pad byte %0h exp 70", pad_byte_o));
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(!done_o && limit_o == '0 && head_o == '0, "R1",
          $sformatf("after release: done %0b limit %0d head %0d, exp 0", done_o, limit_o, head_o));

    // R2: bad page counts
    run_case(40, 20, 100, 0, 1'b0);
    run_case(40, 20, 100, 4, 1'b0);
    run_case(5, 0, 0, 7, 1'b1);
    // R3: snapshot
    run_case(77, 10, 80, 1, 1'b1);
    run_case(300, 0, 0, 3, 1'b1);
    // R4: pad capped by size
    run_case(3, 2, 1000, 1, 1'b0);
    run_case(3, 200, 1000, 2, 1'b0);
    // R5, R7, R8, R9 directed
    run_case(64, 0, 1000, 1, 1'b0);
    run_case(0, 256, 70, 2, 1'b0);
    run_case(16, 30, 1000, 1, 1'b0);
    run_case(100, 128, 1000, 1, 1'b0);
    // R6: tail rule, wrapped and not
    run_case(0, 200, 1000, 2, 1'b0);
    run_case(200, 180, 1000, 2, 1'b0);

    // R11: start held while busy is ignored, single pulse, fixed latency
    launch(0, 128, 1000, 1, 1'b0);
    head_i = 16'd5; size_i = 16'd3; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    wait_done(lat);
    check(done_o && limit_o == 10'd128 && pad_len_o == '0 && head_o == '0 && lat == 1,
          "R11", $sformatf("busy start: limit %0d exp 128, pad %0d exp 0, head %0d exp 0, lat %0d exp 1",
          limit_o, pad_len_o, head_o, lat));
    extra = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (done_o) extra = extra + 1;
    end
    check(extra == 0, "R11", $sformatf("extra done pulses %0d exp 0", extra));

    // sweep over two buffer sizes
    for (int pl = 1; pl <= 2; pl++) begin
      int bs;
      bs = 64 << pl;
      for (int h = 0; h < 2 * bs; h += 9) begin
        for (int s = 0; s <= bs; s += 11) begin
          for (int k = 0; k < 4; k++) begin
            int w;
            case (k)
              0: w = (h > 5) ? h - 5 : 0;
              1: w = h + s / 2;
              2: w = h + s + 3;
              default: w = h + 1;
            endcase
            run_case(h, s, w, pl, 1'b0);
          end
        end
      end
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule